// File: doc/BRIEF.md
# Real-Time Clock Counter Front End with Read-Coherency Carry Flag

This block is the counting front of a real-time clock. A 7-bit sub-second counter advances on every pulse of a 128 Hz tick input. When it passes its top value it steps a seconds counter kept as two BCD digits, which runs from 00 to 59 and then starts again. Software reaches both counters and an 8-bit control register over a simple synchronous register bus with an address, write strobe, write data, read strobe and registered read data.

Software reads the counters at arbitrary moments, so a read can land right as a tick changes them. The control register holds a carry flag that records this. A read of either counter sets the flag when a tick arrives in the same clock cycle as the read strobe or in the cycle after it. Software that sees the flag set clears it by writing 0 and reads again. Writing 1 sets the flag. A second bit of the control register enables an interrupt output driven by the flag.

A retain input stands for standby operation. While it is high, a reset leaves the counters and the control register unchanged. The carry flag has no defined reset value, so software must write it before relying on it.

Top module: `rtc_carry_frontend`

## Requirements
- R1: The sub-second counter is 7 bits wide. It increments by one on every clock cycle in which tick is high and goes from 127 to 0. A read of address 0 returns it zero-extended to 8 bits.
- R2: A read of address 1 returns the seconds as BCD, with tens in bits 7:4 and ones in bits 3:0. The seconds step by one when the sub-second counter goes from 127 to 0, and go from 59 to 00.
- R3: A read of address 0 or 1 sets the carry flag (bit 7 of the control register, address 2) when tick is high in the read cycle or in the cycle after it. The read data is the counter value from before that tick. Reads of address 2 never set the flag.
- R4: A write to address 2 loads bits 6:0 from the write data. Write-data bit 7 equal to 0 clears the carry flag, and equal to 1 sets it.
- R5: A cycle with rst_n low and retain low clears both counters, control bits 6:0 and the read data. It leaves the carry flag unspecified.
- R6: When a race-setting condition and a write of 0 to the carry flag happen in the same cycle, the flag ends up set.
- R7: irq is high exactly when the carry flag and control bit 4 are both 1.
- R8: While retain is high, rst_n low has no effect on the counters or the control register.
- R9: Writes to addresses 0, 1 and 3 change nothing. A read of address 3 returns 0.
- R10: rd_data updates on the clock edge that samples rd_en and holds between reads. A tick two or more cycles after a counter read does not set the carry flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retain | input | 1 | Standby retention; blocks the reset while high |
| tick | input | 1 | One-cycle pulse at 128 Hz |
| addr | input | 2 | Register address (0 sub-second, 1 seconds, 2 control, 3 unused) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Carry interrupt request |

## Verification
The hardest case to reach from the ports is a read that races a tick, because the race window is only two cycles long. The bench owns the tick input, so it puts the tick exactly in the read cycle, one cycle later, or two cycles later, and checks that only the first two set the flag. A further cycle combines the race with a software clear, and a later one clears the flag and re-reads to confirm the value matches the arithmetic model. The seconds rollover needs 7680 ticks, so the bench pulses tick every cycle and walks the whole minute.

// File: rtl/rtc_cf_pkg.sv
// Package: shared register addresses and control bit positions for the
// real-time clock front end. Assumes a 2-bit register address bus.
package rtc_cf_pkg;
    localparam logic [1:0] ADR_SUBSEC  = 2'd0;
    localparam logic [1:0] ADR_SECONDS = 2'd1;
    localparam logic [1:0] ADR_CTRL    = 2'd2;
    localparam int         CF_BIT      = 7;
    localparam int         CIE_BIT     = 4;
endpackage

// File: rtl/rtc_subsec_counter.sv
// Sub-second counter: binary count that steps on each tick and reports a
// wrap pulse when it passes its all-ones value. Assumes tick is a
// one-cycle pulse; reset is synchronous, active low, blocked by retain.
module rtc_subsec_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         retain,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic clear;
    assign clear = !rst_n && !retain;

    // Wrap pulse: tick arriving while the count sits at its top value.
    assign wrap = tick && (count == TOP);

    // Count register: clear on unretained reset, else step per tick.
    always_ff @(posedge clk) begin
        if (clear)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end

    p_subsec_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1));
    p_subsec_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
endmodule

// File: rtl/rtc_bcd_seconds.sv
// Seconds counter: two BCD digits stepped by the sub-second wrap, running
// from 00 to TENS_MAX9 and back to 00. Assumes step is a one-cycle pulse.
module rtc_bcd_seconds #(
    parameter int TENS_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       retain,
    input  logic       step,
    output logic [3:0] tens,
    output logic [3:0] ones
);
    localparam logic [3:0] TENS_LIM = 4'(TENS_MAX);
    localparam logic [3:0] ONES_LIM = 4'd9;

    logic clear;
    assign clear = !rst_n && !retain;

    // Ones digit: wraps at nine, else increments on step.
    always_ff @(posedge clk) begin
        if (clear)
            ones <= '0;
        else if (step)
            ones <= (ones == ONES_LIM) ? 4'd0 : ones + 4'd1;
    end

    // Tens digit: advances on ones carry, wraps at its limit.
    always_ff @(posedge clk) begin
        if (clear)
            tens <= '0;
        else if (step && (ones == ONES_LIM))
            tens <= (tens == TENS_LIM) ? 4'd0 : tens + 4'd1;
    end

    p_bcd_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ones <= ONES_LIM) && (tens <= TENS_LIM));
    p_bcd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable({tens, ones}));
endmodule

// File: rtl/rtc_race_detect.sv
// Race detector: flags a tick that lands in the cycle of a counter read
// or the cycle right after it. Assumes the read data is captured on the
// edge that samples the read strobe.
module rtc_race_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_ctr,
    input  logic tick,
    output logic race_set
);
    logic rd_ctr_q;

    // Remember that the previous cycle held a counter read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ctr_q <= 1'b0;
        else
            rd_ctr_q <= rd_ctr;
    end

    // Race: a tick within the two-cycle window opened by a counter read.
    assign race_set = tick && (rd_ctr || rd_ctr_q);

    p_race_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctr |=> (!tick || race_set));
    p_race_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        race_set |-> tick);
endmodule

// File: rtl/rtc_ctrl_reg.sv
// Control register: bit 7 is the carry flag (set by hardware race or by
// software writing 1, cleared by writing 0), bits 6:0 are plain storage
// with bit 4 gating the interrupt. The carry flag has no reset.
module rtc_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       retain,
    input  logic       wr_ctrl,
    input  logic [7:0] wr_data,
    input  logic       race_set,
    output logic [7:0] ctrl,
    output logic       irq
);
    import rtc_cf_pkg::*;

    logic       cf;
    logic [6:0] low;

    // Lower control bits: cleared by unretained reset, loaded on write.
    always_ff @(posedge clk) begin
        if (!rst_n && !retain)
            low <= '0;
        else if (wr_ctrl)
            low <= wr_data[6:0];
    end

    // Carry flag: hardware race wins over a software write in one cycle.
    always_ff @(posedge clk) begin
        if (race_set)
            cf <= 1'b1;
        else if (wr_ctrl)
            cf <= wr_data[CF_BIT];
    end

    assign ctrl = {cf, low};
    assign irq  = cf && low[CIE_BIT];

    p_cf_race_r6: assert property (@(posedge clk) disable iff (!rst_n)
        race_set |=> cf);
    p_cf_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !race_set) |=> (cf == $past(wr_data[CF_BIT])));
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !low[CIE_BIT] |-> !irq);
endmodule

// File: rtl/rtc_carry_frontend.sv
// Top: real-time clock counter front end. Joins the sub-second and BCD
// seconds counters, the race detector and the control register behind a
// synchronous register bus with registered read data.
module rtc_carry_frontend #(
    parameter int SUB_W    = 7,
    parameter int TENS_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       retain,
    input  logic       tick,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       irq
);
    import rtc_cf_pkg::*;

    logic [SUB_W-1:0] sub_cnt;
    logic             sub_wrap;
    logic [3:0]       sec_tens;
    logic [3:0]       sec_ones;
    logic             rd_ctr;
    logic             race_set;
    logic             wr_ctrl;
    logic [7:0]       ctrl;
    logic [7:0]       rd_next;

    assign rd_ctr  = rd_en && ((addr == ADR_SUBSEC) || (addr == ADR_SECONDS));
    assign wr_ctrl = wr_en && (addr == ADR_CTRL);

    rtc_subsec_counter #(.W(SUB_W)) u_sub (
        .clk(clk), .rst_n(rst_n), .retain(retain), .tick(tick),
        .count(sub_cnt), .wrap(sub_wrap)
    );

    rtc_bcd_seconds #(.TENS_MAX(TENS_MAX)) u_sec (
        .clk(clk), .rst_n(rst_n), .retain(retain), .step(sub_wrap),
        .tens(sec_tens), .ones(sec_ones)
    );

    rtc_race_detect u_race (
        .clk(clk), .rst_n(rst_n), .rd_ctr(rd_ctr), .tick(tick),
        .race_set(race_set)
    );

    rtc_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .retain(retain), .wr_ctrl(wr_ctrl),
        .wr_data(wr_data), .race_set(race_set), .ctrl(ctrl), .irq(irq)
    );

    // Read mux: select the addressed register, unused address reads zero.
    always_comb begin
        case (addr)
            ADR_SUBSEC:  rd_next = 8'(sub_cnt);
            ADR_SECONDS: rd_next = {sec_tens, sec_ones};
            ADR_CTRL:    rd_next = ctrl;
            default:     rd_next = 8'h00;
        endcase
    end

    // Read data register: capture on read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 8'h00;
        else if (rd_en)
            rd_data <= rd_next;
    end

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    p_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 2'd3)) |=> (rd_data == 8'h00));
endmodule

// File: tb/sim_rtc_carry_frontend.sv
// Bench: arithmetic model of tick count, carry flag and control bits;
// drives at the falling edge and samples at the falling edge.
module sim_rtc_carry_frontend;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       retain = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int   n_tests = 0;
    int   n_fail = 0;
    int   n_ticks = 0;
    bit   cf_m = 1'b0;
    bit [6:0] low_m = 7'd0;
    bit   pend_m = 1'b0;
    bit [7:0] rd_m = 8'h00;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    rtc_carry_frontend u0 (
        .clk(clk), .rst_n(rst_n), .retain(retain), .tick(tick),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic bit [7:0] sec_bcd();
        int s = (n_ticks / 128) % 60;
        return {4'(s / 10), 4'(s % 10)};
    endfunction

    function automatic bit [7:0] exp_rd(bit [1:0] a);
        case (a)
            2'd0: return 8'(n_ticks % 128);
            2'd1: return sec_bcd();
            2'd2: return {cf_m, low_m};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive, take the edge, update the model, settle.
    task automatic cyc(bit t, bit rd, bit wr, bit [1:0] a, bit [7:0] wd);
        bit race;
        tick = t; rd_en = rd; wr_en = wr; addr = a; wr_data = wd;
        @(posedge clk);
        if (rd) rd_m = exp_rd(a);
        race = t && ((rd && a < 2'd2) || pend_m);
        if (race) cf_m = 1'b1;
        else if (wr && a == 2'd2) cf_m = wd[7];
        if (wr && a == 2'd2) low_m = wd[6:0];
        pend_m = rd && (a < 2'd2);
        if (t) n_ticks++;
        @(negedge clk);
        tick = 0; rd_en = 0; wr_en = 0; addr = 0; wr_data = 0;
    endtask

    task automatic rd_chk(bit [1:0] a, string req);
        cyc(0, 1, 0, a, 8'h00);
        chk(req, rd_data, rd_m);
    endtask

    task automatic wr_ctl(bit [7:0] v);
        cyc(0, 0, 1, 2'd2, v);
    endtask

    task automatic tick_until(int modv, int target);
        while ((n_ticks % modv) != target) cyc(1, 0, 0, 2'd0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5: reset state
        rd_chk(2'd0, "R5 sub after reset");
        rd_chk(2'd1, "R5 sec after reset");
        cyc(0, 1, 0, 2'd2, 8'h00);
        chk("R5 ctrl low bits", rd_data[6:0], 0);
        chk("R5 irq after reset", irq, 0);
        wr_ctl(8'h00);
        // R4: write semantics of carry flag and storage bits
        wr_ctl(8'h80); rd_chk(2'd2, "R4 write 1 sets flag");
        wr_ctl(8'h00); rd_chk(2'd2, "R4 write 0 clears flag");
        wr_ctl(8'h6b); rd_chk(2'd2, "R4 low bits stored");
        // R7: interrupt gating
        wr_ctl(8'h90); chk("R7 irq flag and enable", irq, 1);
        wr_ctl(8'h80); chk("R7 irq enable off", irq, 0);
        wr_ctl(8'h10); chk("R7 irq flag off", irq, 0);
        wr_ctl(8'h00);
        // R1/R2: sweep over a full minute with quiet reads
        for (int k = 0; k < 128 * 61; k++) begin
            cyc(1, 0, 0, 2'd0, 8'h00);
            if (k % 97 == 0) begin
                cyc(0, 0, 0, 2'd0, 8'h00);
                rd_chk(2'd0, "R1 sweep sub");
                cyc(0, 0, 0, 2'd0, 8'h00);
                rd_chk(2'd1, "R2 sweep sec");
                cyc(0, 0, 0, 2'd0, 8'h00);
            end
        end
        rd_chk(2'd2, "R10 no flag from quiet reads");
        // R1: wrap 127 -> 0
        tick_until(128, 127);
        rd_chk(2'd0, "R1 at top");
        cyc(0, 0, 0, 2'd0, 8'h00);
        cyc(1, 0, 0, 2'd0, 8'h00);
        rd_chk(2'd0, "R1 wrap to zero");
        // R2: 59 -> 00
        tick_until(7680, 7679);
        rd_chk(2'd1, "R2 at 59");
        cyc(0, 0, 0, 2'd0, 8'h00);
        cyc(1, 0, 0, 2'd0, 8'h00);
        cyc(0, 0, 0, 2'd0, 8'h00);
        rd_chk(2'd1, "R2 wrap to 00");
        // R3: race in same cycle, data is pre-tick value
        wr_ctl(8'h00);
        cyc(1, 1, 0, 2'd0, 8'h00);
        chk("R3 same-cycle data pre-tick", rd_data, rd_m);
        rd_chk(2'd2, "R3 same-cycle flag set");
        wr_ctl(8'h00);
        rd_chk(2'd0, "R3 re-read consistent");
        rd_chk(2'd2, "R3 flag clear after re-read");
        // R3: race in following cycle on seconds
        cyc(0, 1, 0, 2'd1, 8'h00);
        cyc(1, 0, 0, 2'd0, 8'h00);
        rd_chk(2'd2, "R3 next-cycle flag set");
        wr_ctl(8'h00);
        // R10: tick two cycles late, and read data hold
        cyc(0, 1, 0, 2'd0, 8'h00);
        rd_m = rd_data;
        cyc(0, 0, 0, 2'd0, 8'h00);
        cyc(1, 0, 0, 2'd0, 8'h00);
        cyc(1, 0, 0, 2'd0, 8'h00);
        chk("R10 rd_data holds", rd_data, rd_m);
        rd_chk(2'd2, "R10 late tick no flag");
        // R3: control read with tick is not a race
        cyc(1, 1, 0, 2'd2, 8'h00);
        rd_chk(2'd2, "R3 ctrl read no flag");
        // R6: race beats software clear
        cyc(0, 1, 0, 2'd0, 8'h00);
        cyc(1, 0, 1, 2'd2, 8'h00);
        rd_chk(2'd2, "R6 race wins over clear");
        wr_ctl(8'h00);
        // R9: writes to other addresses ignored
        cyc(0, 0, 1, 2'd0, 8'h55);
        cyc(0, 0, 1, 2'd1, 8'h33);
        cyc(0, 0, 1, 2'd3, 8'hff);
        rd_chk(2'd0, "R9 sub unchanged");
        rd_chk(2'd1, "R9 sec unchanged");
        rd_chk(2'd2, "R9 ctrl unchanged");
        rd_chk(2'd3, "R9 spare reads zero");
        // R8: retained reset keeps state
        wr_ctl(8'h95);
        rst_n = 1'b0; retain = 1'b1;
        repeat (3) cyc(0, 0, 0, 2'd0, 8'h00);
        rst_n = 1'b1; retain = 1'b0; pend_m = 1'b0;
        rd_chk(2'd2, "R8 ctrl retained");
        chk("R8 irq retained", irq, 1);
        rd_chk(2'd0, "R8 sub retained");
        rd_chk(2'd1, "R8 sec retained");
        // R5: full reset clears counters and low bits
        rst_n = 1'b0;
        repeat (2) cyc(0, 0, 0, 2'd0, 8'h00);
        rst_n = 1'b1; n_ticks = 0; low_m = 7'd0; pend_m = 1'b0;
        rd_chk(2'd0, "R5 sub cleared");
        rd_chk(2'd1, "R5 sec cleared");
        cyc(0, 1, 0, 2'd2, 8'h00);
        chk("R5 ctrl low cleared", rd_data[6:0], 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule